// File: doc/BRIEF.md
# Masked Capture Compare Unit

This block checks a freshly acquired sequence of state samples against a stored reference image. Each acquired row arrives on a streaming input with its row index. The row is compared bit by bit with the reference row that has the same index. A channel mask chooses which bit positions take part in the comparison, and a configurable start/end row window chooses which rows are compared at all. Every compared row produces a registered difference flag, so a downstream viewer can highlight it. When the window is closed, the block gives a verdict: whether the region matched, how many rows differed, and the lowest differing row. It also drives a stop request for repetitive acquisition, raised either on equal or on not-equal as configured.

The reference image lives in an internal memory and has two sources. A host write port has per-bit write enables, so a single bit can be edited in place. A copy mode writes the acquired rows straight into the image at their own indices instead of comparing them. Rows are expected in ascending index order. When an acquisition ends before the end row is reached, the rows that never arrived count as differing.

Top module: `mask_capture_compare`

## Requirements
- R1: An in-range row is flagged as differing exactly when some bit with mask value 1 differs between the acquired data and the reference row of the same index.
- R2: Bit positions whose mask bit is 0 never cause a row to be flagged or counted. The mask is all ones after reset.
- R3: Rows whose index is below `cfg_start_row` or above `cfg_end_row` produce no difference flag and are not counted.
- R4: For each compared row, `row_diff_valid` pulses high for one cycle two clock edges after the row is accepted. `row_diff` and `row_diff_idx` carry that row's result and index.
- R5: `done` pulses for one cycle two edges after the end row, or after a row marked `acq_last`, whichever comes first. At that point `match` and `mismatch_count` give the verdict. Rows arriving after that are ignored until `acq_start`.
- R6: If the acquisition ends before `cfg_end_row` is reached, every in-range row that never arrived adds one to `mismatch_count`.
- R7: `first_diff_row` holds the lowest differing row, counting missing rows as differing. `first_diff_valid` marks that such a row exists.
- R8: `stop_req` is set with `done`. With `cfg_stop_on_equal`=1 it is set when the region matched; with 0 it is set when it did not. It holds until `acq_start`.
- R9: A valid row with `acq_copy`=1 is written whole into the reference at its index, takes no part in comparison, and produces no flag.
- R10: A host write updates only the reference bits whose `ref_wbe` bit is 1; the other bits of that row keep their value.
- R11: Reset (synchronous, active high) and `acq_start` clear `done`, `match`, `stop_req`, `mismatch_count`, `first_diff_valid` and `row_diff_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start_row | input | AW | First row index of the compare window |
| cfg_end_row | input | AW | Last row index of the compare window |
| cfg_stop_on_equal | input | 1 | 1: stop request on match, 0: on mismatch |
| mask_we | input | 1 | Load the channel mask |
| mask_wdata | input | W | New mask, 1 = bit compared |
| ref_we | input | 1 | Host write to the reference image |
| ref_addr | input | AW | Host write row |
| ref_wdata | input | W | Host write data |
| ref_wbe | input | W | Per-bit write enables for the host write |
| acq_start | input | 1 | Begin a new acquisition, clears results |
| acq_valid | input | 1 | Acquired row present |
| acq_copy | input | 1 | Row is copied into the reference instead of compared |
| acq_last | input | 1 | Row is the last of the acquisition |
| acq_idx | input | AW | Row index of the acquired row |
| acq_data | input | W | Acquired row data |
| row_diff_valid | output | 1 | Row result strobe |
| row_diff | output | 1 | Row differs from the reference |
| row_diff_idx | output | AW | Index of the reported row |
| done | output | 1 | Verdict strobe |
| match | output | 1 | Compared region equal |
| stop_req | output | 1 | Stop request for repetitive runs |
| mismatch_count | output | AW+1 | Number of differing rows |
| first_diff_valid | output | 1 | A differing row exists |
| first_diff_row | output | AW | Lowest differing row |

## Verification
The hardest case to reach is an acquisition that stops partway through the window. The verdict must then add the rows that never arrived, and the first difference must point at the first missing row, not at any acquired one. The bench builds this by sending two matching in-range rows and marking the second as last. A second case is the gap between closing the window and the next start: the table sends a differing row after the end row and expects neither a flag nor a change to the verdict. Bit editing is shown through the mask: after a single-bit host edit, one differing row appears. Masking exactly that bit restores a match only if the rest of the row kept its copied value.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  typedef enum logic {
    STOP_ON_DIFF  = 1'b0,
    STOP_ON_EQUAL = 1'b1
  } stop_mode_e;
endpackage

// File: rtl/mcc_ref_ram.sv
module mcc_ref_ram #(
  parameter int W  = 16,
  parameter int D  = 64,
  parameter int AW = $clog2(D)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  wbe,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [D];

  always_ff @(posedge clk) begin
    for (int b = 0; b < W; b++) begin
      if (we && wbe[b]) mem[waddr][b] <= wdata[b];
    end
    rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (we) AST_WADDR_LEGAL: assert (int'(waddr) < D); // R10
  end
endmodule

// File: rtl/mcc_row_compare.sv
module mcc_row_compare #(
  parameter int W  = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acq_start,
  input  logic          acq_valid,
  input  logic          acq_copy,
  input  logic          acq_last,
  input  logic [AW-1:0] acq_idx,
  input  logic [W-1:0]  acq_data,
  input  logic [AW-1:0] start_row,
  input  logic [AW-1:0] end_row,
  input  logic [W-1:0]  mask,
  input  logic [W-1:0]  ref_q,
  output logic          cmp_valid,
  output logic          cmp_diff,
  output logic          cmp_fin,
  output logic [AW-1:0] cmp_idx,
  output logic          row_diff_valid,
  output logic          row_diff,
  output logic [AW-1:0] row_diff_idx
);
  logic          s1_cmp, s1_fin, closed;
  logic [AW-1:0] s1_idx;
  logic [W-1:0]  s1_data;
  logic [W-1:0]  bit_miss;
  logic          accept, in_rng, fin_now;

  assign accept  = acq_valid && !acq_copy && !closed;
  assign in_rng  = (acq_idx >= start_row) && (acq_idx <= end_row);
  assign fin_now = accept && ((in_rng && acq_idx == end_row) || acq_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_cmp <= 1'b0;
      s1_fin <= 1'b0;
      closed <= 1'b0;
    end else begin
      s1_cmp <= accept && in_rng;
      s1_fin <= fin_now;
      if (acq_start)    closed <= 1'b0;
      else if (fin_now) closed <= 1'b1;
    end
    s1_idx  <= acq_idx;
    s1_data <= acq_data;
  end

  // per-channel masked difference
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign bit_miss[b] = mask[b] & (s1_data[b] ^ ref_q[b]);
  end

  assign cmp_valid = s1_cmp;
  assign cmp_diff  = |bit_miss;
  assign cmp_fin   = s1_fin;
  assign cmp_idx   = s1_idx;

  always_ff @(posedge clk) begin
    if (rst || acq_start) begin
      row_diff_valid <= 1'b0;
      row_diff       <= 1'b0;
      row_diff_idx   <= '0;
    end else begin
      row_diff_valid <= s1_cmp;
      row_diff       <= s1_cmp && cmp_diff;
      row_diff_idx   <= s1_idx;
    end
  end

  AST_FLAG_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    row_diff_valid |-> (row_diff_idx >= start_row && row_diff_idx <= end_row)); // R3
  AST_FLAG_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    row_diff |-> row_diff_valid); // R4
  AST_CLOSED_NO_CMP: assert property (@(posedge clk) disable iff (rst)
    (closed && !acq_start) |=> !s1_cmp); // R5
endmodule

// File: rtl/mcc_verdict.sv
module mcc_verdict #(
  parameter int AW = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                acq_start,
  input  logic                cmp_valid,
  input  logic                cmp_diff,
  input  logic                cmp_fin,
  input  logic [AW-1:0]       cmp_idx,
  input  logic [AW-1:0]       start_row,
  input  logic [AW-1:0]       end_row,
  input  mcc_pkg::stop_mode_e mode,
  output logic                done,
  output logic                match,
  output logic                stop_req,
  output logic [AW:0]         mismatch_count,
  output logic                first_diff_valid,
  output logic [AW-1:0]       first_diff_row
);
  logic [AW:0] nxt, st, en, lo, gap, gap_use, cnt_next;
  logic        add_diff;

  assign add_diff = cmp_valid && cmp_diff;
  assign nxt      = {1'b0, cmp_idx} + 1'b1;
  assign st       = {1'b0, start_row};
  assign en       = {1'b0, end_row};
  assign lo       = (nxt > st) ? nxt : st;
  assign gap      = (lo <= en) ? (en - lo + 1'b1) : '0;
  assign gap_use  = cmp_fin ? gap : '0;
  assign cnt_next = mismatch_count + (AW+1)'(add_diff) + gap_use;

  always_ff @(posedge clk) begin
    if (rst || acq_start) begin
      done             <= 1'b0;
      match            <= 1'b0;
      stop_req         <= 1'b0;
      mismatch_count   <= '0;
      first_diff_valid <= 1'b0;
      first_diff_row   <= '0;
    end else begin
      mismatch_count <= cnt_next;
      done           <= cmp_fin;
      if (!first_diff_valid) begin
        if (add_diff) begin
          first_diff_valid <= 1'b1;
          first_diff_row   <= cmp_idx;
        end else if (gap_use != '0) begin
          first_diff_valid <= 1'b1;
          first_diff_row   <= lo[AW-1:0];
        end
      end
      if (cmp_fin) begin
        match    <= (cnt_next == '0);
        stop_req <= (mode == mcc_pkg::STOP_ON_EQUAL) ? (cnt_next == '0) : (cnt_next != '0);
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R5
  AST_STOP_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(stop_req) |-> done); // R8
  AST_MATCH_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
    match |-> (mismatch_count == '0)); // R5
  AST_COUNT_GROWS: assert property (@(posedge clk) disable iff (rst)
    !$past(acq_start) |-> (mismatch_count >= $past(mismatch_count))); // R6
endmodule

// File: rtl/mask_capture_compare.sv
module mask_capture_compare #(
  parameter int W     = 16,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] cfg_start_row,
  input  logic [AW-1:0] cfg_end_row,
  input  logic          cfg_stop_on_equal,
  input  logic          mask_we,
  input  logic [W-1:0]  mask_wdata,
  input  logic          ref_we,
  input  logic [AW-1:0] ref_addr,
  input  logic [W-1:0]  ref_wdata,
  input  logic [W-1:0]  ref_wbe,
  input  logic          acq_start,
  input  logic          acq_valid,
  input  logic          acq_copy,
  input  logic          acq_last,
  input  logic [AW-1:0] acq_idx,
  input  logic [W-1:0]  acq_data,
  output logic          row_diff_valid,
  output logic          row_diff,
  output logic [AW-1:0] row_diff_idx,
  output logic          done,
  output logic          match,
  output logic          stop_req,
  output logic [AW:0]   mismatch_count,
  output logic          first_diff_valid,
  output logic [AW-1:0] first_diff_row
);
  logic [W-1:0]        mask_q, ref_q;
  logic                copy_wr, ram_we;
  logic [AW-1:0]       ram_waddr;
  logic [W-1:0]        ram_wdata, ram_wbe;
  logic                cmp_valid, cmp_diff, cmp_fin;
  logic [AW-1:0]       cmp_idx;
  mcc_pkg::stop_mode_e mode;

  assign mode = mcc_pkg::stop_mode_e'(cfg_stop_on_equal);

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '1;
    else if (mask_we) mask_q <= mask_wdata;
  end

  // copied acquisition rows take the single write port ahead of the host
  assign copy_wr   = acq_valid && acq_copy;
  assign ram_we    = copy_wr || ref_we;
  assign ram_waddr = copy_wr ? acq_idx  : ref_addr;
  assign ram_wdata = copy_wr ? acq_data : ref_wdata;
  assign ram_wbe   = copy_wr ? '1       : ref_wbe;

  mcc_ref_ram #(.W(W), .D(DEPTH), .AW(AW)) ram_i (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .wbe(ram_wbe), .raddr(acq_idx), .rdata(ref_q)
  );

  mcc_row_compare #(.W(W), .AW(AW)) cmp_i (
    .clk(clk), .rst(rst), .acq_start(acq_start), .acq_valid(acq_valid),
    .acq_copy(acq_copy), .acq_last(acq_last), .acq_idx(acq_idx),
    .acq_data(acq_data), .start_row(cfg_start_row), .end_row(cfg_end_row),
    .mask(mask_q), .ref_q(ref_q), .cmp_valid(cmp_valid), .cmp_diff(cmp_diff),
    .cmp_fin(cmp_fin), .cmp_idx(cmp_idx), .row_diff_valid(row_diff_valid),
    .row_diff(row_diff), .row_diff_idx(row_diff_idx)
  );

  mcc_verdict #(.AW(AW)) verdict_i (
    .clk(clk), .rst(rst), .acq_start(acq_start), .cmp_valid(cmp_valid),
    .cmp_diff(cmp_diff), .cmp_fin(cmp_fin), .cmp_idx(cmp_idx),
    .start_row(cfg_start_row), .end_row(cfg_end_row), .mode(mode),
    .done(done), .match(match), .stop_req(stop_req),
    .mismatch_count(mismatch_count), .first_diff_valid(first_diff_valid),
    .first_diff_row(first_diff_row)
  );

  AST_COPY_SILENT: assert property (@(posedge clk) disable iff (rst)
    (acq_valid && acq_copy && !acq_start) |=> ##1 !row_diff_valid); // R9
endmodule

// File: tb/mask_capture_compare_tb.sv
module mask_capture_compare_tb_top;
  localparam int W = 16, DEPTH = 64, AW = 6;

  logic clk = 0, rst = 1;
  logic [AW-1:0] cfg_start_row = 0, cfg_end_row = 0;
  logic cfg_stop_on_equal = 0, mask_we = 0, ref_we = 0;
  logic [W-1:0] mask_wdata = 0, ref_wdata = 0, ref_wbe = 0, acq_data = 0;
  logic [AW-1:0] ref_addr = 0, acq_idx = 0;
  logic acq_start = 0, acq_valid = 0, acq_copy = 0, acq_last = 0;
  logic row_diff_valid, row_diff, done, match, stop_req, first_diff_valid;
  logic [AW-1:0] row_diff_idx, first_diff_row;
  logic [AW:0] mismatch_count;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  mask_capture_compare #(.W(W), .DEPTH(DEPTH)) dut_i (.*);

  // fields: idx[25:20] xor[19:4] last[3] exp_valid[2] exp_flag[1] exp_done[0]
  localparam logic [25:0] VEC [8] = '{
    {6'd0, 16'hFFFF, 4'b0000},
    {6'd1, 16'h0000, 4'b0000},
    {6'd2, 16'h0000, 4'b0100},
    {6'd3, 16'h00F0, 4'b0100},
    {6'd4, 16'h0100, 4'b0110},
    {6'd5, 16'h0000, 4'b0100},
    {6'd6, 16'h8000, 4'b0111},
    {6'd7, 16'h0001, 4'b0000}
  };

  function automatic logic [W-1:0] refv(input int i);
    return 16'hA5C3 ^ (16'(i) * 16'h0101);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic send(input int idx, input logic [W-1:0] d, input logic last, input logic cp);
    @(negedge clk);
    acq_valid = 1; acq_idx = AW'(idx); acq_data = d; acq_last = last; acq_copy = cp;
    @(negedge clk);
    acq_valid = 0; acq_last = 0; acq_copy = 0;
    @(negedge clk);
  endtask

  task automatic host_wr(input int a, input logic [W-1:0] d, input logic [W-1:0] be);
    @(negedge clk);
    ref_we = 1; ref_addr = AW'(a); ref_wdata = d; ref_wbe = be;
    @(negedge clk);
    ref_we = 0;
  endtask

  task automatic set_mask(input logic [W-1:0] m);
    @(negedge clk); mask_we = 1; mask_wdata = m;
    @(negedge clk); mask_we = 0;
  endtask

  task automatic begin_acq();
    @(negedge clk); acq_start = 1;
    @(negedge clk); acq_start = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20ns * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(done, 0, "R11 done after reset");
    chk(match, 0, "R11 match after reset");
    chk(stop_req, 0, "R11 stop_req after reset");
    chk(32'(mismatch_count), 0, "R11 count after reset");
    chk(row_diff_valid, 0, "R11 row_diff_valid after reset");
    @(negedge clk); rst = 0;

    // R10 load reference rows
    for (int i = 0; i < 8; i++) host_wr(i, refv(i), '1);

    // table walk: mask FF0F, window 2..6, stop on difference
    set_mask(16'hFF0F);
    cfg_start_row = 2; cfg_end_row = 6; cfg_stop_on_equal = 0;
    begin_acq();
    for (int k = 0; k < 8; k++) begin
      logic [25:0] v;
      v = VEC[k];
      send(int'(v[25:20]), refv(int'(v[25:20])) ^ v[19:4], v[3], 1'b0);
      chk(row_diff_valid, v[2], "R3 row_diff_valid for table row");
      if (v[2]) begin
        chk(row_diff, v[1], "R1 R2 row_diff for table row");
        chk(32'(row_diff_idx), 32'(v[25:20]), "R4 row_diff_idx");
      end
      chk(done, v[0], "R5 done strobe in table");
    end
    chk(32'(mismatch_count), 2, "R5 count after table");
    chk(first_diff_valid, 1, "R7 first valid after table");
    chk(32'(first_diff_row), 4, "R7 first row after table");
    chk(match, 0, "R5 match after table");
    chk(stop_req, 1, "R8 stop on difference");

    // R6 early end, stop on equal
    cfg_stop_on_equal = 1;
    begin_acq();
    chk(stop_req, 0, "R11 acq_start clears stop_req");
    send(2, refv(2), 0, 0);
    send(3, refv(3), 1, 0);
    chk(done, 1, "R5 done on last row");
    chk(32'(mismatch_count), 3, "R6 missing rows counted");
    chk(32'(first_diff_row), 4, "R7 first missing row");
    chk(match, 0, "R6 match with missing rows");
    chk(stop_req, 0, "R8 no stop on mismatch in equal mode");

    // R8 equal run
    cfg_start_row = 1; cfg_end_row = 3;
    begin_acq();
    for (int i = 1; i <= 3; i++) send(i, refv(i), 0, 0);
    chk(match, 1, "R8 match on equal run");
    chk(stop_req, 1, "R8 stop on equal");
    chk(first_diff_valid, 0, "R7 no first diff on equal run");

    // R9 copy rows into the reference, then compare
    begin_acq();
    for (int i = 10; i <= 12; i++) begin
      send(i, 16'h1234 + 16'(i), 0, 1);
      chk(row_diff_valid, 0, "R9 no flag while copying");
    end
    chk(done, 0, "R9 no verdict while copying");
    cfg_start_row = 10; cfg_end_row = 12;
    begin_acq();
    for (int i = 10; i <= 12; i++) send(i, 16'h1234 + 16'(i), 0, 0);
    chk(match, 1, "R9 copied image matches");
    chk(32'(mismatch_count), 0, "R9 count after copy");

    // R10 single-bit edit of row 11 (0x123F -> bit0 to 0)
    host_wr(11, 16'h0000, 16'h0001);
    begin_acq();
    send(10, 16'h123E, 0, 0);
    send(11, 16'h123F, 0, 0);
    chk(row_diff, 1, "R10 edited row flagged");
    chk(32'(row_diff_idx), 11, "R10 edited row index");
    send(12, 16'h1240, 0, 0);
    chk(32'(mismatch_count), 1, "R10 single differing row");
    chk(32'(first_diff_row), 11, "R7 first diff is edited row");
    chk(stop_req, 0, "R8 no stop on edited mismatch");

    // R2 mask out the edited bit: other bits must be intact
    set_mask(16'hFFFE);
    begin_acq();
    for (int i = 10; i <= 12; i++) send(i, 16'h1234 + 16'(i), 0, 0);
    chk(match, 1, "R2 R10 masked bit ignored, rest intact");
    chk(32'(mismatch_count), 0, "R2 count with masked bit");

    finish_run();
  end
endmodule